// File: doc/BRIEF.md
# Expanded-Bus Memory Map Decoder

This block produces the chip selects for memory and I/O devices hung on a 16-bit external address bus. From the upper address bits, the data-phase strobe and the read/write line, it picks one of four 1K RAM banks at the bottom of the map, one of four 4K ROM banks at the top, or a single 4K I/O page at 8000h. It also drives a ROM output enable that is asserted only for reads.

All selects are active low and registered, so they appear one clock after the inputs that cause them. An asynchronous reset forces every select high.

A parameter chooses how the RAM window is decoded. In full mode RAM answers only in 0000h–0FFFh. In partial mode only the top address bit qualifies RAM, so the 4K window repeats every 4K through the lower half of the map. This saves decode gates when software knows the mirrors are shared.

Top module: `mmd_memmap_decoder`

## Requirements
- R1: With the strobe high and the address in 0000h–0FFFh, exactly one RAM select goes low. The bank number is address bits 11:10, and bank n drives `ram_cs_no[n]`.
- R2: With `FULL_DECODE=1`, RAM is selected only when address bits 15:12 are all zero. Addresses 1000h–7FFFh assert no select.
- R3: With `FULL_DECODE=0`, address bits 14:12 are ignored for RAM. Any address with bit 15 = 0 selects RAM bank bits 11:10, so 0000h–0FFFh mirrors at 1000h, 2000h and on up to 7000h.
- R4: With the strobe high and the address in C000h–FFFFh, exactly one ROM select goes low. The bank number is address bits 13:12, and bank n drives `rom_cs_no[n]`.
- R5: With the strobe high and address bits 15:12 = 1000b (8000h–8FFFh), `io_cs_no` goes low.
- R6: While the strobe `e_i` is low, every select and the ROM output enable stay high, whatever the address.
- R7: `rom_oe_no` goes low only when a ROM bank is selected and `rw_i` = 1 (read). A ROM-region access with `rw_i` = 0 lowers the ROM select and leaves `rom_oe_no` high.
- R8: At most one select is low at any time. Addresses 9000h–BFFFh assert no select.
- R9: While `rst_ni` is low, all outputs are high, and this takes effect at once, without waiting for a clock edge.
- R10: Each output reflects the inputs sampled at the previous rising clock edge: there is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Bus address |
| e_i | input | 1 | Data-phase strobe, high enables selects |
| rw_i | input | 1 | 1 = read, 0 = write |
| ram_cs_no | output | 4 | RAM bank selects, active low |
| rom_cs_no | output | 4 | ROM bank selects, active low |
| io_cs_no | output | 1 | I/O page select, active low |
| rom_oe_no | output | 1 | ROM output enable, active low |

## Verification
The assertions assume that the address, strobe and read/write inputs hold known values across each sampling edge. They also assume that an output reflects only the inputs at the previous edge, so address changes between edges carry no meaning. The stimulus keeps to this by changing every input on the falling clock edge, one access per cycle. The address space is walked in 256-byte steps, with extra points on each bank and region boundary. Both decode modes are driven with the same sequence, so mirrored and unmirrored answers are compared address by address.

// File: rtl/mmd_pkg.sv
package mmd_pkg;
  localparam int unsigned ADDR_W = 16;

  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RAM  = 2'd1,
    REG_ROM  = 2'd2,
    REG_IO   = 2'd3
  } region_e;

  // Fixed map anchors (upper nibble of the address)
  localparam logic [3:0] IO_PAGE  = 4'h8;
  localparam logic [1:0] ROM_TOP2 = 2'b11;
endpackage

// File: rtl/mmd_region_decode.sv
module mmd_region_decode
  import mmd_pkg::*;
#(
  parameter bit FULL_DECODE = 1'b1
) (
  input  logic [3:0] page_hi_i,
  output region_e    region_o
);
  logic ram_hit;

  generate
    if (FULL_DECODE) begin : g_full
      assign ram_hit = (page_hi_i == 4'h0);
    end else begin : g_partial
      assign ram_hit = ~page_hi_i[3];
    end
  endgenerate

  always_comb begin
    if (ram_hit)                          region_o = REG_RAM;
    else if (page_hi_i[3:2] == ROM_TOP2)  region_o = REG_ROM;
    else if (page_hi_i == IO_PAGE)        region_o = REG_IO;
    else                                  region_o = REG_NONE;
  end
endmodule

// File: rtl/mmd_bank_sel.sv
module mmd_bank_sel #(
  parameter int unsigned BANKS = 4,
  localparam int unsigned IDX_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [BANKS-1:0] sel_no
);
  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    assign sel_no[i] = ~(en_i && (idx_i == IDX_W'(i)));
  end
endmodule

// File: rtl/mmd_memmap_decoder.sv
module mmd_memmap_decoder
  import mmd_pkg::*;
#(
  parameter bit          FULL_DECODE = 1'b1,
  parameter int unsigned RAM_BANKS   = 4,
  parameter int unsigned ROM_BANKS   = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 e_i,
  input  logic                 rw_i,
  output logic [RAM_BANKS-1:0] ram_cs_no,
  output logic [ROM_BANKS-1:0] rom_cs_no,
  output logic                 io_cs_no,
  output logic                 rom_oe_no
);
  localparam int unsigned RAM_IDX_W = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 1;
  localparam int unsigned ROM_IDX_W = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 1;
  localparam int unsigned RAM_LSB   = 10;  // 1K RAM banks
  localparam int unsigned ROM_LSB   = 12;  // 4K ROM banks

  region_e region;
  logic    ram_en, rom_en, io_en, oe_en;
  logic [RAM_BANKS-1:0] ram_d;
  logic [ROM_BANKS-1:0] rom_d;
  logic [RAM_BANKS-1:0] ram_q;
  logic [ROM_BANKS-1:0] rom_q;
  logic io_q, oe_q;
  logic unused_addr_bits;

  assign unused_addr_bits = ^addr_i[RAM_LSB-1:0];

  mmd_region_decode #(.FULL_DECODE(FULL_DECODE)) u_region (
    .page_hi_i (addr_i[ADDR_W-1 -: 4]),
    .region_o  (region)
  );

  assign ram_en = e_i && (region == REG_RAM);
  assign rom_en = e_i && (region == REG_ROM);
  assign io_en  = e_i && (region == REG_IO);
  assign oe_en  = rom_en && rw_i;

  mmd_bank_sel #(.BANKS(RAM_BANKS)) u_ram_sel (
    .en_i   (ram_en),
    .idx_i  (addr_i[RAM_LSB +: RAM_IDX_W]),
    .sel_no (ram_d)
  );

  mmd_bank_sel #(.BANKS(ROM_BANKS)) u_rom_sel (
    .en_i   (rom_en),
    .idx_i  (addr_i[ROM_LSB +: ROM_IDX_W]),
    .sel_no (rom_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_q <= '1;
      rom_q <= '1;
      io_q  <= 1'b1;
      oe_q  <= 1'b1;
    end else begin
      ram_q <= ram_d;
      rom_q <= rom_d;
      io_q  <= ~io_en;
      oe_q  <= ~oe_en;
    end
  end

  assign ram_cs_no = ram_q;
  assign rom_cs_no = rom_q;
  assign io_cs_no  = io_q;
  assign rom_oe_no = oe_q;

  AST_AT_MOST_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(~{ram_cs_no, rom_cs_no, io_cs_no}) <= 1); // R8

  AST_E_GATES_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(e_i) |-> (&{ram_cs_no, rom_cs_no, io_cs_no, rom_oe_no})); // R6

  AST_OE_READ_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_oe_no |-> $past(rw_i)); // R7

  AST_OE_WITH_ROM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_oe_no |-> !(&rom_cs_no)); // R7

  AST_IO_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_cs_no |-> ($past(addr_i[ADDR_W-1 -: 4]) == IO_PAGE)); // R5

  AST_ROM_REGION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&rom_cs_no) |-> ($past(addr_i[ADDR_W-1 -: 2]) == ROM_TOP2)); // R4

  generate
    if (FULL_DECODE) begin : g_ast_full
      AST_RAM_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(&ram_cs_no) |-> ($past(addr_i[ADDR_W-1 -: 4]) == 4'h0)); // R2
    end else begin : g_ast_part
      AST_RAM_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(&ram_cs_no) |-> !$past(addr_i[ADDR_W-1])); // R3
    end
  endgenerate
endmodule

// File: tb/sim_mmd_memmap_decoder.sv
`timescale 1ns/1ps
module sim_mmd_memmap_decoder;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic [15:0] addr;
  logic        e, rw;
  logic [3:0]  ram0, rom0, ram1, rom1;
  logic        io0, oe0, io1, oe1;

  int errs = 0;
  int checks = 0;

  typedef struct {
    logic [15:0] a;
    logic        e;
    logic        rw;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  mmd_memmap_decoder #(.FULL_DECODE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .e_i(e), .rw_i(rw),
    .ram_cs_no(ram0), .rom_cs_no(rom0), .io_cs_no(io0), .rom_oe_no(oe0));

  mmd_memmap_decoder #(.FULL_DECODE(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .e_i(e), .rw_i(rw),
    .ram_cs_no(ram1), .rom_cs_no(rom1), .io_cs_no(io1), .rom_oe_no(oe1));

  // Layout: {io, rom_oe, rom[3:0], ram[3:0]}, active low
  function automatic logic [9:0] model(logic [15:0] a, logic en, logic rd, bit full);
    logic [9:0] r;
    logic       ram_hit;
    r = '1;
    ram_hit = full ? (a[15:12] == 4'h0) : !a[15];
    if (en) begin
      if (ram_hit) r[a[11:10]] = 1'b0;
      else if (a[15:14] == 2'b11) begin
        r[4 + a[13:12]] = 1'b0;
        if (rd) r[8] = 1'b0;
      end else if (a[15:12] == 4'h8) r[9] = 1'b0;
    end
    return r;
  endfunction

  function automatic string tag(logic [15:0] a, logic en, logic rd, bit full);
    if (!en) return "R6";
    if (a[15:12] == 4'h0) return "R1";
    if (!a[15]) return full ? "R2" : "R3";
    if (a[15:14] == 2'b11) return rd ? "R4" : "R7";
    if (a[15:12] == 4'h8) return "R5";
    return "R8";
  endfunction

  task automatic chk(string req, logic [9:0] act, logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] a, logic en, logic rd);
    item_t it;
    @(negedge clk);
    addr = a; e = en; rw = rd;
    it.a = a; it.e = en; it.rw = rd;
    q.push_back(it);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // Monitor: outputs sampled 1 ns after the edge that captured the item (R10)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk({tag(it.a, it.e, it.rw, 1'b1), "/R10 full a=", $sformatf("%h", it.a)},
            {io0, oe0, rom0, ram0}, model(it.a, it.e, it.rw, 1'b1));
        chk({tag(it.a, it.e, it.rw, 1'b0), "/R10 partial a=", $sformatf("%h", it.a)},
            {io1, oe1, rom1, ram1}, model(it.a, it.e, it.rw, 1'b0));
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    errs++; checks++;
    $display("FAIL watchdog: act=hung exp=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    addr = 16'hC000; e = 1'b1; rw = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset full",    {io0, oe0, rom0, ram0}, '1);
    chk("R9 reset partial", {io1, oe1, rom1, ram1}, '1);
    rst_ni = 1'b1;

    // Walk of the whole map, reads: R1..R5, R8
    for (int p = 0; p < 256; p++) drive(16'(p * 256) | 16'h00A5, 1'b1, 1'b1);

    // Bank and region edges
    drive(16'h03FF, 1'b1, 1'b1); drive(16'h0400, 1'b1, 1'b1);
    drive(16'h0BFF, 1'b1, 1'b1); drive(16'h0FFF, 1'b1, 1'b1);
    drive(16'h1000, 1'b1, 1'b1); drive(16'h2C00, 1'b1, 1'b1);
    drive(16'h7FFF, 1'b1, 1'b1); drive(16'h8000, 1'b1, 1'b1);
    drive(16'h8FFF, 1'b1, 1'b1); drive(16'h9000, 1'b1, 1'b1);
    drive(16'hBFFF, 1'b1, 1'b1); drive(16'hC000, 1'b1, 1'b1);
    drive(16'hDFFF, 1'b1, 1'b1); drive(16'hE000, 1'b1, 1'b1);
    drive(16'hFFFF, 1'b1, 1'b1);

    // Writes: ROM select without output enable (R7)
    for (int p = 0; p < 64; p++) drive(16'(p * 1024) | 16'h0013, 1'b1, 1'b0);

    // Strobe low: nothing selected (R6)
    drive(16'h0000, 1'b0, 1'b1); drive(16'h0C00, 1'b0, 1'b0);
    drive(16'h3400, 1'b0, 1'b1); drive(16'h8000, 1'b0, 1'b1);
    drive(16'hC000, 1'b0, 1'b1); drive(16'hF000, 1'b0, 1'b0);
    drive(16'hE123, 1'b1, 1'b1);  // strobe back on

    repeat (3) @(negedge clk);

    // Async reset while a ROM read is held on the bus (R9)
    drive(16'hD000, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R9 async full",    {io0, oe0, rom0, ram0}, '1);
    chk("R9 async partial", {io1, oe1, rom1, ram1}, '1);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule